// File: doc/BRIEF.md
# Reset Supervisor with Manual Inputs

This block produces the active-low system reset for a board or subsystem. It has three sources. The first is a supply-good indication from a comparator. The other two are independent active-low manual reset lines, such as push buttons or a processor's reset pin wired back in.

A supply failure pulls the reset output low at once, without waiting for a clock. When the supply returns, the output stays low for a fixed recovery time and is then released. A falling edge on either manual line starts a reset pulse of that same recovery time. While a reset is in progress, the manual lines are ignored. The recovery time is the parameter `TREC_CYCLES`, counted in cycles of a free-running clock.

The block also drives a supply-switch status output. It shows whether the output supply currently comes from the main supply or from the battery.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_ok` is 0, `sys_rst_n` is 0 in the same cycle, with no clock edge needed. The reset counter is held at its start value.
- R2: After `pwr_ok` rises, `pwr_ok` passes a two-flop synchronizer. `sys_rst_n` goes high on the (TREC_CYCLES+2)-th rising clock edge after the rise.
- R3: Each manual input is synchronized by two flops. A falling edge on either input while `sys_rst_n` is 1 drives `sys_rst_n` low on the third rising edge after the input falls.
- R4: A reset started by a manual input holds `sys_rst_n` low for exactly TREC_CYCLES clock cycles.
- R5: While `sys_rst_n` is 0, falling edges on either manual input are ignored. They neither restart nor extend the pulse.
- R6: A manual input that is still low when `sys_rst_n` is released does not start another reset. Only a new falling edge does.
- R7: Both manual inputs falling in the same cycle produce a single pulse of TREC_CYCLES cycles.
- R8: `supply_sw_n` follows `on_battery` in the same cycle. It is 0 when the output supply comes from the main supply (`on_battery`=0) and 1 when it comes from the battery (`on_battery`=1).
- R9: The internal recovery count never reaches TREC_CYCLES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| pwr_ok | input | 1 | Supply-good indication. 0 means the supply has failed and also clears the block asynchronously |
| man_a_n | input | 1 | First manual reset request, active low, asynchronous |
| man_b_n | input | 1 | Second manual reset request, active low, asynchronous |
| on_battery | input | 1 | Switchover decision, 1 when the output supply is taken from the battery |
| sys_rst_n | output | 1 | System reset, active low |
| supply_sw_n | output | 1 | Supply-switch status, low while the output supply comes from the main supply |

## Verification
The hardest case to reach is a supply failure that lands in the middle of a manual pulse. The block must drop its partial count and restart the full recovery after the supply returns. The bench starts a manual reset, drops `pwr_ok` partway through with the button still held, and checks that the output falls immediately. It then restores the supply after releasing the button and measures a complete power-up recovery. Other scenarios press a second button inside an active pulse, and hold a button well past the release of reset.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int TREC_CYCLES = 16
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic man_a_n,
  input  logic man_b_n,
  input  logic on_battery,
  output logic sys_rst_n,
  output logic supply_sw_n
);
  localparam int CW = $clog2(TREC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TREC_CYCLES - 1);

  logic [1:0]    pg_sync;
  logic [2:0]    a_sync, b_sync;
  logic          active;
  logic [CW-1:0] cnt;

  wire pg     = pg_sync[1];
  wire fall_a = a_sync[2] & ~a_sync[1];
  wire fall_b = b_sync[2] & ~b_sync[1];

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok) begin
      pg_sync <= '0;
      a_sync  <= '1;
      b_sync  <= '1;
    end else begin
      pg_sync <= {pg_sync[0], 1'b1};
      a_sync  <= {a_sync[1:0], man_a_n};
      b_sync  <= {b_sync[1:0], man_b_n};
    end

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (!pg) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (fall_a || fall_b) begin
      active <= 1'b1;
      cnt    <= '0;
    end

  assign sys_rst_n   = pwr_ok & ~active;
  assign supply_sw_n = on_battery;

  a_r1_hold_while_bad: assert property (@(posedge clk) disable iff (!pwr_ok)
    !pg |-> (active && cnt == '0));

  a_r2_release_after_recovery: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(active) |-> $past(cnt) == LAST);

  a_r3_edge_starts_pulse: assert property (@(posedge clk) disable iff (!pwr_ok)
    (pg && !active && (fall_a || fall_b)) |=> (active && cnt == '0));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!pwr_ok)
    (pg && active && cnt != LAST) |=> (active && cnt == $past(cnt) + 1'b1));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!pwr_ok)
    cnt <= LAST);
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb_top;
  localparam int TREC = 8;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0, man_a_n = 1'b1, man_b_n = 1'b1, on_battery = 1'b1;
  logic sys_rst_n, supply_sw_n;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rst_supervisor #(.TREC_CYCLES(TREC)) dut_i (
    .clk(clk), .pwr_ok(pwr_ok), .man_a_n(man_a_n), .man_b_n(man_b_n),
    .on_battery(on_battery), .sys_rst_n(sys_rst_n), .supply_sw_n(supply_sw_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel[1]=b, sel[0]=a ; hold = negedge at which inputs release ; extra = negedge b is pulsed (0 none)
  localparam logic [17:0] VEC [6] = '{
    {2'b01, 8'd1,  8'd0},
    {2'b10, 8'd3,  8'd0},
    {2'b11, 8'd2,  8'd0},
    {2'b01, 8'd20, 8'd0},
    {2'b10, 8'd30, 8'd0},
    {2'b01, 8'd2,  8'd5}
  };

  task automatic run_press(input logic [1:0] sel, input int hold, input int extra,
                           output int dly, output int lowc, output int relow);
    logic seen_hi;
    @(negedge clk);
    man_a_n = !sel[0];
    man_b_n = !sel[1];
    dly = -1; lowc = 0; relow = 0; seen_hi = 1'b0;
    for (int k = 1; k <= hold + 40; k++) begin
      @(negedge clk);
      if (!sys_rst_n) begin
        if (dly < 0) dly = k;
        if (seen_hi) relow++; else lowc++;
      end else if (dly >= 0) seen_hi = 1'b1;
      if (k == hold) begin man_a_n = 1'b1; if (extra == 0) man_b_n = 1'b1; end
      if (extra != 0 && k == extra) man_b_n = 1'b0;
      if (extra != 0 && k == extra + 2) man_b_n = 1'b1;
    end
  endtask

  task automatic power_up(output int lowc, output int relow);
    logic seen_hi;
    @(negedge clk);
    pwr_ok = 1'b1;
    lowc = 0; relow = 0; seen_hi = 1'b0;
    for (int k = 1; k <= TREC + 30; k++) begin
      @(negedge clk);
      if (!sys_rst_n) begin
        if (seen_hi) relow++; else lowc++;
      end else seen_hi = 1'b1;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d, l, r;
    repeat (3) @(negedge clk);
    check("R1 reset state", sys_rst_n, 0);
    check("R8 battery", supply_sw_n, 1);
    on_battery = 1'b0; #1;
    check("R8 main", supply_sw_n, 0);

    power_up(l, r);
    check("R2 power-up low cycles", l, TREC + 1);
    check("R2 no relow", r, 0);

    foreach (VEC[i]) begin
      run_press(VEC[i][17:16], int'(VEC[i][15:8]), int'(VEC[i][7:0]), d, l, r);
      check($sformatf("R3 latency vec %0d", i), d, 3);
      check($sformatf("R4/R5/R7 width vec %0d", i), l, TREC);
      check($sformatf("R6 no retrigger vec %0d", i), r, 0);
    end

    @(negedge clk);
    pwr_ok = 1'b0; #1;
    check("R1 glitch immediate low", sys_rst_n, 0);
    power_up(l, r);
    check("R2 after glitch", l, TREC + 1);

    @(negedge clk);
    man_a_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 manual active", sys_rst_n, 0);
    pwr_ok = 1'b0; #1;
    check("R1 fail during manual", sys_rst_n, 0);
    repeat (5) @(negedge clk);
    check("R1 held while bad", sys_rst_n, 0);
    man_a_n = 1'b1;
    power_up(l, r);
    check("R2 full recovery after mid-pulse fail", l, TREC + 1);
    check("R6 no relow after fail", r, 0);

    on_battery = 1'b1; #1;
    check("R8 back to battery", supply_sw_n, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule